// File: doc/BRIEF.md
# Dual-Drive Programmed-I/O Strobe Timing Generator

This block times programmed-I/O transfers for two drives that share one cable: a master (drive 0) and a slave (drive 1). Software works out the clock counts and writes them as packed timing words. There are four of them, one read word and one write word for each drive. A shared control word carries the address-setup length, a read-prefetch enable and a ready-wait length. The block counts bus clocks and plays out each transfer as a setup phase, a strobe phase and a recovery phase. It then returns to idle and marks completion with a one-cycle done pulse.

Requests arrive on a valid/ready handshake carrying the drive number and the direction. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A requester that sees `req_ready` low must hold `req_valid`, `req_drive` and `req_write` steady until the handshake completes. The request is never lost. The block samples the timing fields at the moment it accepts a request, so software may rewrite the words during a transfer without disturbing it. The data path and the conversion from nanoseconds to clocks are outside this block.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset `busy`, `done`, `rd_strobe` and `wr_strobe` are low and `req_ready` is high.
- R2: An accepted transfer runs setup, then strobe, then recovery, then idle. For a read (`req_write`=0) only `rd_strobe` is high during the strobe phase, and for a write (`req_write`=1) only `wr_strobe` is high. The two strobes are never high together. `cyc_drive` shows the drive of the transfer in progress.
- R3: The strobe phase lasts (bits [7:4] of the selected timing word) + 1 clocks, which is 1 to 16. The selected word is the read or write word of drive 0 (`*_m`) or drive 1 (`*_s`).
- R4: The recovery phase lasts (bits [3:0] of the selected timing word) + 2 clocks, which is 2 to 17. It is never shorter than two clocks.
- R5: The setup phase lasts (bits [5:4] of `misc_word`) + 1 clocks, which is 1 to 4. The same value applies to both drives.
- R6: `done` is high for exactly one clock: the first idle cycle after the last recovery clock.
- R7: `req_ready` is low for as long as `busy` is high. A request held with `req_valid` high during a transfer is accepted on the first idle cycle, and `busy` is high on the next cycle.
- R8: The timing words, `misc_word` and `drive_present` are sampled on the accepting edge. Changes to them during a transfer do not change that transfer's phase lengths.
- R9: A transfer to a drive whose `drive_present` bit is 0 uses setup 1, strobe 1 and recovery 2 clocks, whatever the words hold.
- R10: `prefetch_en` follows bit 6 of `misc_word`. `drdy_clks` equals (bits [2:1] of `misc_word`) + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_word_m | input | 8 | Read timing word, drive 0 |
| wr_word_m | input | 8 | Write timing word, drive 0 |
| rd_word_s | input | 8 | Read timing word, drive 1 |
| wr_word_s | input | 8 | Write timing word, drive 1 |
| misc_word | input | 8 | Shared setup, prefetch and ready-wait fields |
| drive_present | input | 2 | Bit n high when drive n is fitted |
| req_valid | input | 1 | Transfer request pending |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_drive | input | 1 | Target drive of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cyc_drive | output | 1 | Drive of the current transfer |
| prefetch_en | output | 1 | Read prefetch enable |
| drdy_clks | output | 3 | Decoded ready-wait length in clocks |

## Verification
The bench drives all-zero and all-one timing words to probe the ends of the field ranges. A wrong bias shows up as a phase one clock too long or too short, and a 4-bit counter overflow shows up as a 16-clock strobe collapsing to 0 or a 17-clock recovery wrapping. It rewrites every word and the presence mask in the middle of a transfer. A design that reads its timing live would then stretch or cut short the phase it is in. It holds a second request while a first transfer runs, which exposes a dropped request or a ready that rises early. It also sends a transfer to an absent drive, which catches a design that still reads the absent drive's words.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;

endpackage

// File: rtl/pio_tword_decode.sv
module pio_tword_decode #(
  parameter int FIELD_W = 4,
  parameter int CNT_W   = FIELD_W + 1
) (
  input  logic [2*FIELD_W-1:0] word,
  input  logic                 present,
  output logic [CNT_W-1:0]     act_len,
  output logic [CNT_W-1:0]     rec_len
);
  localparam int ACT_LSB = FIELD_W;
  localparam logic [CNT_W-1:0] ACT_BIAS = CNT_W'(1);
  localparam logic [CNT_W-1:0] REC_BIAS = CNT_W'(2);

  logic [CNT_W-1:0] act_raw;
  logic [CNT_W-1:0] rec_raw;

  always_comb begin
    act_raw = CNT_W'(word[ACT_LSB +: FIELD_W]) + ACT_BIAS;
    rec_raw = CNT_W'(word[0 +: FIELD_W]) + REC_BIAS;
    act_len = present ? act_raw : ACT_BIAS;
    rec_len = present ? rec_raw : REC_BIAS;
  end
endmodule

// File: rtl/pio_misc_decode.sv
module pio_misc_decode #(
  parameter int MISC_W  = 8,
  parameter int SETUP_W = 2,
  parameter int DRDY_W  = 2,
  parameter int CNT_W   = 5
) (
  input  logic [MISC_W-1:0] misc,
  output logic [CNT_W-1:0]  setup_len,
  output logic              prefetch_en,
  output logic [DRDY_W:0]   drdy_clks
);
  localparam int PF_BIT    = 6;
  localparam int SETUP_LSB = 4;
  localparam int DRDY_LSB  = 1;
  localparam int DCLK_W    = DRDY_W + 1;

  logic unused_misc_bits;
  assign unused_misc_bits = ^{misc[MISC_W-1], misc[3], misc[0]};

  always_comb begin
    setup_len   = CNT_W'(misc[SETUP_LSB +: SETUP_W]) + CNT_W'(1);
    prefetch_en = misc[PF_BIT];
    drdy_clks   = DCLK_W'(misc[DRDY_LSB +: DRDY_W]) + DCLK_W'(2);
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_tmg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_drive,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] rec_len,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             busy,
  output logic             done,
  output logic             cyc_drive
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  pio_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;
  logic             wr_q;
  logic             drv_q;
  logic             done_q;
  logic             last;

  assign last = (cnt == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= ZERO;
      act_q  <= ONE;
      rec_q  <= CNT_W'(2);
      wr_q   <= 1'b0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase <= PH_SETUP;
            cnt   <= setup_len - ONE;
            act_q <= act_len;
            rec_q <= rec_len;
            wr_q  <= req_write;
            drv_q <= req_drive;
          end
        end
        PH_SETUP: begin
          if (last) begin
            phase <= PH_ACTIVE;
            cnt   <= act_q - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_ACTIVE: begin
          if (last) begin
            phase <= PH_RECOV;
            cnt   <= rec_q - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: begin
          if (last) begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign req_ready = (phase == PH_IDLE);
  assign rd_strobe = (phase == PH_ACTIVE) && !wr_q;
  assign wr_strobe = (phase == PH_ACTIVE) && wr_q;
  assign done      = done_q;
  assign cyc_drive = drv_q;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));

  assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_strobe) || $rose(wr_strobe)) |-> ($past(phase) == PH_SETUP));

  assert_rec_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV && $past(phase) != PH_RECOV) |=> (phase == PH_RECOV));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_RECOV && phase == PH_IDLE));

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (phase == PH_SETUP && busy));

  assert_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |->
      ($stable(act_q) && $stable(rec_q) && $stable(wr_q) && $stable(drv_q)));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int FIELD_W = 4,
  parameter int MISC_W  = 8,
  parameter int SETUP_W = 2,
  parameter int DRDY_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*FIELD_W-1:0] rd_word_m,
  input  logic [2*FIELD_W-1:0] wr_word_m,
  input  logic [2*FIELD_W-1:0] rd_word_s,
  input  logic [2*FIELD_W-1:0] wr_word_s,
  input  logic [MISC_W-1:0]    misc_word,
  input  logic [1:0]           drive_present,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_drive,
  input  logic                 req_write,
  output logic                 rd_strobe,
  output logic                 wr_strobe,
  output logic                 busy,
  output logic                 done,
  output logic                 cyc_drive,
  output logic                 prefetch_en,
  output logic [DRDY_W:0]      drdy_clks
);
  localparam int WORD_W  = 2 * FIELD_W;
  localparam int CNT_W   = FIELD_W + 1;
  localparam int NUM_DRV = 2;

  logic [WORD_W-1:0] rd_words [NUM_DRV];
  logic [WORD_W-1:0] wr_words [NUM_DRV];
  logic [CNT_W-1:0]  act_by_drv [NUM_DRV];
  logic [CNT_W-1:0]  rec_by_drv [NUM_DRV];
  logic [CNT_W-1:0]  setup_shared;
  logic [CNT_W-1:0]  setup_sel;

  assign rd_words[0] = rd_word_m;
  assign rd_words[1] = rd_word_s;
  assign wr_words[0] = wr_word_m;
  assign wr_words[1] = wr_word_s;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    logic [WORD_W-1:0] word_sel;
    assign word_sel = req_write ? wr_words[g] : rd_words[g];

    pio_tword_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec (
      .word    (word_sel),
      .present (drive_present[g]),
      .act_len (act_by_drv[g]),
      .rec_len (rec_by_drv[g])
    );
  end

  pio_misc_decode #(
    .MISC_W(MISC_W), .SETUP_W(SETUP_W), .DRDY_W(DRDY_W), .CNT_W(CNT_W)
  ) u_misc (
    .misc        (misc_word),
    .setup_len   (setup_shared),
    .prefetch_en (prefetch_en),
    .drdy_clks   (drdy_clks)
  );

  assign setup_sel = drive_present[req_drive] ? setup_shared : CNT_W'(1);

  pio_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_drive (req_drive),
    .req_write (req_write),
    .setup_len (setup_sel),
    .act_len   (act_by_drv[req_drive]),
    .rec_len   (rec_by_drv[req_drive]),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .busy      (busy),
    .done      (done),
    .cyc_drive (cyc_drive)
  );
endmodule

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rd_word_m = '0, wr_word_m = '0, rd_word_s = '0, wr_word_s = '0;
  logic [7:0] misc_word = '0;
  logic [1:0] drive_present = 2'b11;
  logic       req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0;
  logic       req_ready, rd_strobe, wr_strobe, busy, done, cyc_drive, prefetch_en;
  logic [2:0] drdy_clks;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_word_m(rd_word_m), .wr_word_m(wr_word_m),
    .rd_word_s(rd_word_s), .wr_word_s(wr_word_s),
    .misc_word(misc_word), .drive_present(drive_present),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_drive(req_drive), .req_write(req_write),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .busy(busy), .done(done), .cyc_drive(cyc_drive),
    .prefetch_en(prefetch_en), .drdy_clks(drdy_clks)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_word(input bit drv, input bit wr);
    if (drv) return wr ? wr_word_s : rd_word_s;
    return wr ? wr_word_m : rd_word_m;
  endfunction

  function automatic int exp_setup(input bit drv);
    return drive_present[drv] ? int'(misc_word[5:4]) + 1 : 1;
  endfunction

  function automatic int exp_act(input bit drv, input logic [7:0] w);
    return drive_present[drv] ? int'(w[7:4]) + 1 : 1;
  endfunction

  function automatic int exp_rec(input bit drv, input logic [7:0] w);
    return drive_present[drv] ? int'(w[3:0]) + 2 : 2;
  endfunction

  // Called at the negedge just after the accepting edge.
  task automatic measure(input int es, input int ea, input int er, input bit drv,
                         input bit wr, input bit scramble, input string nm);
    int s = 0, a = 0, r = 0, guard = 0;
    bit seen = 0, wrong = 0, rdy_bad = 0;
    req_valid = 1'b0;
    while (busy && guard < 100) begin
      if (rd_strobe || wr_strobe) begin
        a++; seen = 1;
        if (wr_strobe != wr || rd_strobe == wr || cyc_drive != drv) wrong = 1;
      end else if (!seen) s++;
      else r++;
      if (req_ready) rdy_bad = 1;
      guard++;
      if (scramble && guard == 1) begin
        rd_word_m = 8'($urandom); wr_word_m = 8'($urandom);
        rd_word_s = 8'($urandom); wr_word_s = 8'($urandom);
        misc_word = 8'($urandom); drive_present = 2'($urandom);
      end
      @(negedge clk);
    end
    chk(s == es, {nm, " R5 setup length", scramble ? " R8" : ""}, s, es);
    chk(a == ea, {nm, " R3 strobe length", scramble ? " R8" : ""}, a, ea);
    chk(r == er, {nm, " R4 recovery length", scramble ? " R8" : ""}, r, er);
    chk(!wrong, {nm, " R2 strobe line or drive"}, int'(wrong), 0);
    chk(!rdy_bad, {nm, " R7 ready low while busy"}, int'(rdy_bad), 0);
    chk(done == 1'b1, {nm, " R6 done on first idle cycle"}, int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, {nm, " R6 done single cycle"}, int'(done), 0);
  endtask

  task automatic run(input bit drv, input bit wr, input bit scramble, input string nm);
    logic [7:0] w;
    int es, ea, er;
    w  = pick_word(drv, wr);
    es = exp_setup(drv);
    ea = exp_act(drv, w);
    er = exp_rec(drv, w);
    req_drive = drv; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    measure(es, ea, er, drv, wr, scramble, nm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rd_strobe && !wr_strobe, "R1 idle outputs after reset",
        int'({busy, done, rd_strobe, wr_strobe}), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // R10 decode of shared word
    misc_word = 8'b0100_0110; #1;
    chk(prefetch_en == 1'b1, "R10 prefetch enable", int'(prefetch_en), 1);
    chk(drdy_clks == 3'd5, "R10 ready-wait clocks", int'(drdy_clks), 5);
    misc_word = 8'h00; #1;
    chk(prefetch_en == 1'b0, "R10 prefetch disable", int'(prefetch_en), 0);
    chk(drdy_clks == 3'd2, "R10 ready-wait default", int'(drdy_clks), 2);

    // Directed extremes
    rd_word_m = 8'hFF; wr_word_m = 8'h00; rd_word_s = 8'h5A; wr_word_s = 8'hA5;
    misc_word = 8'h30; drive_present = 2'b11;
    run(1'b0, 1'b0, 1'b0, "max fields m-rd");
    run(1'b0, 1'b1, 1'b0, "min fields m-wr");
    run(1'b1, 1'b0, 1'b0, "mid fields s-rd");
    misc_word = 8'h00;
    run(1'b1, 1'b1, 1'b0, "min setup s-wr");

    // R9 absent drive
    rd_word_s = 8'hFF; misc_word = 8'h30; drive_present = 2'b01;
    run(1'b1, 1'b0, 1'b0, "R9 absent slave");
    drive_present = 2'b11;

    // R8 mid-cycle rewrite
    rd_word_m = 8'h73; misc_word = 8'h20;
    run(1'b0, 1'b0, 1'b1, "R8 rewrite");
    drive_present = 2'b11;

    // R7 held request
    begin
      int ea, er, es;
      bit rbad = 0;
      rd_word_m = 8'h00; wr_word_s = 8'h32; misc_word = 8'h10;
      req_drive = 1'b0; req_write = 1'b0; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_drive = 1'b1; req_write = 1'b1;
      while (busy) begin
        if (req_ready) rbad = 1;
        @(negedge clk);
      end
      chk(!rbad, "R7 ready held low during transfer", int'(rbad), 0);
      chk(done == 1'b1, "R6 done before held request", int'(done), 1);
      chk(req_ready == 1'b1, "R7 ready on idle cycle", int'(req_ready), 1);
      es = exp_setup(1'b1); ea = exp_act(1'b1, wr_word_s); er = exp_rec(1'b1, wr_word_s);
      @(negedge clk);
      chk(busy == 1'b1, "R7 held request accepted", int'(busy), 1);
      measure(es, ea, er, 1'b1, 1'b1, 1'b0, "R7 held");
    end

    // Constrained random
    for (int i = 0; i < 40; i++) begin
      rd_word_m = 8'($urandom); wr_word_m = 8'($urandom);
      rd_word_s = 8'($urandom); wr_word_s = 8'($urandom);
      misc_word = 8'($urandom);
      drive_present = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      run(1'($urandom), 1'($urandom), 1'($urandom % 3 == 0), "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule